// File: doc/BRIEF.md
# Low-Power Mode Exit Sequencer

This block governs the power state of the control core of a clock generator. Software drives a small control word: a power-down request, two exit options (skip pin resampling, skip the non-volatile autoload) and an idle policy. The block enters low power when software requests it, or when both clock outputs are disabled and the idle policy asks for a full power-down. When both outputs are disabled the outputs are always muted, even if the policy keeps the device powered.

Leaving low power follows a fixed order. First comes one resample cycle. In that cycle the synchronized format/address pin either picks OTP mode or I2C mode, or I2C mode is forced when resampling is disabled. Then comes an optional autoload, which copies a fixed number of words from an external OTP page store into the register file at one word per cycle. Only after both steps does the block release mute and raise clock-ready. Clock-ready can be routed to the reference-control pin, and the synchronized configuration pins are exposed as read-only status.

Top module: `lpm_exit_seq`

## Requirements
- R1: Control word encoding: bit 0 is the power-down request, bit 1 disables autoload, bit 2 disables resampling, and bit 3 selects mute-only idle. The word reads back on `ctlRdData`, and its reset value is 4'b1000.
- R2: A write that sets bit 0 updates the control word at that clock edge. `lowPower` rises after the following edge. Clearing bit 0 while in low power starts the exit sequence at the next edge.
- R3: `mute` is high whenever both `outEnA` and `outEnB` are low, and whenever the block is not in the active state. With bit 3 at 0, both outputs low also enter low power. With bit 3 at 1 the block only mutes.
- R4: A write changes bits 1 and 2 only when it is accepted while `lowPower` is high. At any other time those bits keep their value, while bits 0 and 3 are still written.
- R5: The exit takes one resample cycle, then NWORDS autoload cycles if autoload is enabled, and then the active state. `clkReady` is high only in the active state, so it is low during low power and during the whole exit.
- R6: With resampling enabled, the resample cycle latches `otpMode` from bit 0 of the synchronized pins (1 selects OTP mode, 0 selects I2C mode). With resampling disabled, `otpMode` is forced to 0. The mode holds until the next resample.
- R7: An autoload asserts `busy` and, in each of NWORDS consecutive cycles, asserts `otpRdEn` and `cfgWrEn`. Addresses run from 0 to NWORDS-1, and `cfgWrData` equals `otpRdData` in the same cycle. With autoload disabled, no read or write is issued.
- R8: `pinStatus` shows `cfgPins` through a two-flop synchronizer and changes on the second edge after a pin change.
- R9: `refPinOut` equals `clkReady` when `refReadyRole` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlWrEn | input | 1 | Control word write strobe |
| ctlWrData | input | 4 | Control word write data |
| ctlRdData | output | 4 | Control word readback |
| outEnA | input | 1 | Enable of clock output A |
| outEnB | input | 1 | Enable of clock output B |
| cfgPins | input | NPINS | Asynchronous configuration pins, bit 0 is the format/address pin |
| refReadyRole | input | 1 | Reference-control pin is in clock-ready role |
| otpRdEn | output | 1 | OTP page read strobe |
| otpAddr | output | ADDR_W | OTP word address |
| otpRdData | input | DATA_W | OTP read data, valid in the same cycle |
| cfgWrEn | output | 1 | Register file write strobe |
| cfgWrAddr | output | ADDR_W | Register file write address |
| cfgWrData | output | DATA_W | Register file write data |
| pinStatus | output | NPINS | Synchronized pin readback |
| otpMode | output | 1 | 1 = OTP mode, 0 = I2C mode |
| mute | output | 1 | Clock outputs muted |
| lowPower | output | 1 | Device in low-power state |
| busy | output | 1 | Autoload in progress |
| clkReady | output | 1 | Clocks ready |
| refPinOut | output | 1 | Reference-control pin drive |

## Verification
The bench runs all four combinations of the two exit options and measures exit latency, the latched mode and the register-file contents. A design that reordered the steps or raised clock-ready early would shorten the latency. A design that ignored the resample-disable bit would latch OTP mode. A design that always copied the page would overwrite sentinel words.

Writes to the protected option bits are attempted outside low power. A design that accepted them would show a changed readback. The idle policy is tried both ways with both outputs off, so a design that tied muting to power-down shows up. A per-cycle reference model also catches off-by-one autoload addresses, and synchronizer depths other than two.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int CTL_W = 4;
  localparam int CTL_PDN = 0;
  localparam int CTL_NOLOAD = 1;
  localparam int CTL_NORES = 2;
  localparam int CTL_IDLE = 3;
  localparam logic [CTL_W-1:0] CTL_RESET = 4'b1000;

  typedef enum logic [1:0] {
    ST_ACTIVE   = 2'd0,
    ST_LOWPWR   = 2'd1,
    ST_RESAMPLE = 2'd2,
    ST_LOAD     = 2'd3
  } lpmState_t;

  typedef struct packed {
    logic latchMode;
    logic forceI2c;
    logic cntClr;
    logic cntInc;
  } dpStrobe_t;
endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  input  logic             outEnA,
  input  logic             outEnB,
  input  logic             cntLast,
  output dpStrobe_t        strobe,
  output logic [CTL_W-1:0] ctlReg,
  output logic             lowPower,
  output logic             mute,
  output logic             clkReady,
  output logic             busy
);
  lpmState_t state, stateNext;
  logic bothOff, enterLow;

  assign bothOff  = !outEnA && !outEnB;
  assign enterLow = ctlReg[CTL_PDN] || (bothOff && !ctlReg[CTL_IDLE]);

  // Option bits are writable only while powered down
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg <= CTL_RESET;
    end else if (ctlWrEn) begin
      ctlReg[CTL_PDN]  <= ctlWrData[CTL_PDN];
      ctlReg[CTL_IDLE] <= ctlWrData[CTL_IDLE];
      if (state == ST_LOWPWR) begin
        ctlReg[CTL_NOLOAD] <= ctlWrData[CTL_NOLOAD];
        ctlReg[CTL_NORES]  <= ctlWrData[CTL_NORES];
      end
    end
  end

  always_comb begin
    stateNext = state;
    strobe = '0;
    unique case (state)
      ST_ACTIVE:   if (enterLow) stateNext = ST_LOWPWR;
      ST_LOWPWR:   if (!enterLow) stateNext = ST_RESAMPLE;
      ST_RESAMPLE: begin
        strobe.latchMode = !ctlReg[CTL_NORES];
        strobe.forceI2c  = ctlReg[CTL_NORES];
        strobe.cntClr    = 1'b1;
        stateNext = ctlReg[CTL_NOLOAD] ? ST_ACTIVE : ST_LOAD;
      end
      ST_LOAD: begin
        strobe.cntInc = 1'b1;
        if (cntLast) stateNext = ST_ACTIVE;
      end
      default: stateNext = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= stateNext;
  end

  assign lowPower = (state == ST_LOWPWR);
  assign busy     = (state == ST_LOAD);
  assign clkReady = (state == ST_ACTIVE);
  assign mute     = (state != ST_ACTIVE) || bothOff;

  // R3: low power always mutes
  assert_lowpower_mutes_R3: assert property (@(posedge clk) disable iff (!rstN)
    lowPower |-> mute);
  // R5: ready, busy and low power never overlap
  assert_exclusive_status_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lowPower, busy, clkReady}));
  // R5: ready only rises at the end of an exit sequence
  assert_ready_after_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkReady) |-> ($past(state) == ST_RESAMPLE || $past(state) == ST_LOAD));
  // R4: option bits frozen outside low power
  assert_options_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_LOWPWR) |=> $stable(ctlReg[CTL_NORES:CTL_NOLOAD]));
endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int NWORDS  = 12,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int NPINS   = 4,
  parameter int FMT_PIN = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [NPINS-1:0]  cfgPins,
  input  logic [DATA_W-1:0] otpRdData,
  output logic [NPINS-1:0]  pinStatus,
  output logic              otpMode,
  output logic              cntLast,
  output logic              otpRdEn,
  output logic [ADDR_W-1:0] otpAddr,
  output logic              cfgWrEn,
  output logic [ADDR_W-1:0] cfgWrAddr,
  output logic [DATA_W-1:0] cfgWrData
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NWORDS - 1);

  logic [ADDR_W-1:0] wordCnt;

  for (genvar p = 0; p < NPINS; p++) begin : g_pinSync
    logic syncA, syncB;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
      end else begin
        syncA <= cfgPins[p];
        syncB <= syncA;
      end
    end
    assign pinStatus[p] = syncB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 otpMode <= 1'b0;
    else if (strobe.latchMode) otpMode <= pinStatus[FMT_PIN];
    else if (strobe.forceI2c)  otpMode <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wordCnt <= '0;
    else if (strobe.cntClr) wordCnt <= '0;
    else if (strobe.cntInc) wordCnt <= wordCnt + 1'b1;
  end

  assign cntLast   = (wordCnt == LAST_ADDR);
  assign otpRdEn   = strobe.cntInc;
  assign otpAddr   = wordCnt;
  assign cfgWrEn   = strobe.cntInc;
  assign cfgWrAddr = wordCnt;
  assign cfgWrData = otpRdData;

  // R7: autoload addresses advance by one per cycle
  assert_addr_steps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (otpRdEn && !cntLast) |=> (otpRdEn && otpAddr == $past(otpAddr) + 1'b1));
  // R6: disabled resample leaves I2C mode
  assert_forced_i2c_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.forceI2c |=> !otpMode);
  // R6: mode holds between resamples
  assert_mode_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.latchMode || strobe.forceI2c) |=> $stable(otpMode));
endmodule

// File: rtl/lpm_exit_seq.sv
module lpm_exit_seq
  import lpm_pkg::*;
#(
  parameter int NWORDS  = 12,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int NPINS   = 4,
  parameter int FMT_PIN = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [CTL_W-1:0]  ctlWrData,
  output logic [CTL_W-1:0]  ctlRdData,
  input  logic              outEnA,
  input  logic              outEnB,
  input  logic [NPINS-1:0]  cfgPins,
  input  logic              refReadyRole,
  output logic              otpRdEn,
  output logic [ADDR_W-1:0] otpAddr,
  input  logic [DATA_W-1:0] otpRdData,
  output logic              cfgWrEn,
  output logic [ADDR_W-1:0] cfgWrAddr,
  output logic [DATA_W-1:0] cfgWrData,
  output logic [NPINS-1:0]  pinStatus,
  output logic              otpMode,
  output logic              mute,
  output logic              lowPower,
  output logic              busy,
  output logic              clkReady,
  output logic              refPinOut
);
  dpStrobe_t strobe;
  logic cntLast;

  lpm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .outEnA(outEnA), .outEnB(outEnB), .cntLast(cntLast), .strobe(strobe),
    .ctlReg(ctlRdData), .lowPower(lowPower), .mute(mute),
    .clkReady(clkReady), .busy(busy)
  );

  lpm_datapath #(
    .NWORDS(NWORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .NPINS(NPINS), .FMT_PIN(FMT_PIN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgPins(cfgPins),
    .otpRdData(otpRdData), .pinStatus(pinStatus), .otpMode(otpMode),
    .cntLast(cntLast), .otpRdEn(otpRdEn), .otpAddr(otpAddr),
    .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr), .cfgWrData(cfgWrData)
  );

  assign refPinOut = refReadyRole && clkReady;

  // R9: reference pin never shows ready outside its role
  assert_refpin_role_R9: assert property (@(posedge clk) disable iff (!rstN)
    !refReadyRole |-> !refPinOut);
endmodule

// File: tb/tb_lpm_exit_seq.sv
`timescale 1ns/1ps
module tb_lpm_exit_seq;
  localparam int N = 12;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk = 0, rstN = 0;
  logic ctlWrEn = 0;
  logic [3:0] ctlWrData = 0, ctlRdData;
  logic outEnA = 1, outEnB = 1, refReadyRole = 0;
  logic [3:0] cfgPins = 0, pinStatus;
  logic otpRdEn, cfgWrEn, otpMode, mute, lowPower, busy, clkReady, refPinOut;
  logic [AW-1:0] otpAddr, cfgWrAddr;
  logic [DW-1:0] otpRdData, cfgWrData;
  logic [7:0] seed = 8'h30;
  logic [7:0] rf [N];
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] otpFn(logic [7:0] s, logic [AW-1:0] a);
    return s ^ (8'(a) * 8'h1D + 8'h03);
  endfunction
  assign otpRdData = otpFn(seed, otpAddr);

  lpm_exit_seq #(.NWORDS(N), .ADDR_W(AW), .DATA_W(DW)) dut (.*);

  always @(posedge clk) if (cfgWrEn) rf[cfgWrAddr] <= cfgWrData;

  task automatic chk(logic ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 active, 1 low power, 2 resample, 3 loading
  int mSt = 0, mCnt = 0;
  logic mMode = 0;
  logic [3:0] mCtl = 4'b1000, mS1 = 0, mS2 = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mCnt = 0; mMode = 0; mCtl = 4'b1000; mS1 = 0; mS2 = 0;
    end else begin
      automatic logic enter = mCtl[0] || (!outEnA && !outEnB && !mCtl[3]);
      automatic int oSt = mSt;
      automatic logic [3:0] oS2 = mS2;
      if (ctlWrEn) begin
        mCtl[0] = ctlWrData[0];
        mCtl[3] = ctlWrData[3];
        if (oSt == 1) mCtl[2:1] = ctlWrData[2:1];
      end
      case (oSt)
        0: if (enter) mSt = 1;
        1: if (!enter) mSt = 2;
        2: begin
          mMode = mCtl_old_nr(oSt) ? 1'b0 : oS2[0];
          mCnt = 0;
          mSt = nextAfterRes;
        end
        default: begin
          if (mCnt == N - 1) mSt = 0;
          mCnt++;
        end
      endcase
      mS2 = mS1;
      mS1 = cfgPins;
    end
  end
  // Option bits as they stood before the edge (only writable in low power, so
  // in the resample cycle the register already holds its pre-edge value)
  function automatic logic mCtl_old_nr(int s);
    return (s == 2) ? mCtl[2] : 1'b0;
  endfunction
  wire nextAfterResLoad = !mCtl[1];
  int nextAfterRes;
  always_comb nextAfterRes = nextAfterResLoad ? 3 : 0;

  always @(posedge clk) begin
    #1;
    if (rstN) begin
      chk(lowPower == (mSt == 1), "R2 lowPower", lowPower, mSt == 1);
      chk(mute == (mSt != 0 || (!outEnA && !outEnB)), "R3 mute", mute,
          mSt != 0 || (!outEnA && !outEnB));
      chk(clkReady == (mSt == 0), "R5 clkReady", clkReady, mSt == 0);
      chk(busy == (mSt == 3) && otpRdEn == (mSt == 3) && cfgWrEn == (mSt == 3),
          "R7 busy/strobes", {busy, otpRdEn, cfgWrEn}, {3{mSt == 3}});
      if (mSt == 3)
        chk(otpAddr == AW'(mCnt) && cfgWrAddr == AW'(mCnt) &&
            cfgWrData == otpFn(seed, AW'(mCnt)), "R7 address/data",
            otpAddr, mCnt);
      chk(otpMode == mMode, "R6 otpMode", otpMode, mMode);
      chk(ctlRdData == mCtl, "R4 ctlRdData", ctlRdData, mCtl);
      chk(pinStatus == mS2, "R8 pinStatus", pinStatus, mS2);
      chk(refPinOut == (refReadyRole && mSt == 0), "R9 refPinOut", refPinOut,
          refReadyRole && mSt == 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(logic [3:0] d);
    @(negedge clk); ctlWrEn = 1; ctlWrData = d;
    @(negedge clk); ctlWrEn = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3); rstN = 1; cyc(1);
    chk(ctlRdData == 4'b1000, "R1 reset control word", ctlRdData, 4'b1000);
    chk(clkReady && !lowPower && !mute && !otpMode, "R1 reset outputs",
        {clkReady, lowPower, mute, otpMode}, 4'b1000);
    // R8: synchronizer depth
    cfgPins = 4'b1100; cyc(1);
    chk(pinStatus == 4'b0000, "R8 not yet through", pinStatus, 0);
    cyc(1);
    chk(pinStatus == 4'b1100, "R8 after two edges", pinStatus, 4'b1100);
    // R9: reference pin role
    refReadyRole = 1; cyc(1);
    chk(refPinOut == 1, "R9 role on", refPinOut, 1);
    refReadyRole = 0; cyc(1);
    chk(refPinOut == 0, "R9 role off", refPinOut, 0);
    // R4: protected bits ignored while active
    wr(4'b1110);
    chk(ctlRdData == 4'b1000, "R4 write outside low power", ctlRdData, 4'b1000);
    // R5 R6 R7: all four option combinations
    for (int c = 0; c < 4; c++) begin
      automatic logic na = c[0], nr = c[1];
      automatic logic fmt = (c != 2);
      automatic int n = 0;
      automatic logic [7:0] exp;
      seed = 8'h30 + 8'(c);
      for (int i = 0; i < N; i++) rf[i] = 8'hEE;
      cfgPins = fmt ? 4'b0101 : 4'b1010;
      wr(4'b1001);
      cyc(1);
      chk(lowPower == 1, "R2 entered low power", lowPower, 1);
      wr({1'b1, nr, na, 1'b1});
      chk(ctlRdData == {1'b1, nr, na, 1'b1}, "R4 write in low power",
          ctlRdData, {1'b1, nr, na, 1'b1});
      wr({1'b1, nr, na, 1'b0});
      while (!clkReady && n < 100) begin cyc(1); n++; end
      chk(n == (na ? 2 : 2 + N), "R5 exit latency", n, na ? 2 : 2 + N);
      chk(otpMode == (nr ? 1'b0 : fmt), "R6 mode outcome", otpMode,
          nr ? 1'b0 : fmt);
      for (int i = 0; i < N; i++) begin
        exp = na ? 8'hEE : otpFn(seed, AW'(i));
        chk(rf[i] == exp, "R7 register file word", rf[i], exp);
      end
    end
    // R4: protected bits hold after exit
    wr(4'b1000);
    chk(ctlRdData == 4'b1110, "R4 clear attempt while active", ctlRdData, 4'b1110);
    // R3: idle policy full power-down
    wr(4'b0000);
    outEnA = 0; outEnB = 0; cyc(3);
    chk(lowPower && mute && !clkReady, "R3 idle power-down",
        {lowPower, mute, clkReady}, 3'b110);
    outEnA = 1; cyc(4);
    chk(clkReady && !mute && !otpMode, "R3 wake on output enable",
        {clkReady, mute, otpMode}, 3'b100);
    // R3: idle policy mute only
    wr(4'b1000);
    outEnA = 0; cyc(3);
    chk(mute && !lowPower && clkReady, "R3 mute-only idle",
        {mute, lowPower, clkReady}, 3'b101);
    outEnB = 1; cyc(1);
    chk(!mute, "R3 unmute", mute, 0);
    cyc(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule